// File: doc/BRIEF.md
# ADC Offset and Gain Corrector

This block turns a raw converter result into a calibrated two's-complement sample. Each accepted word has its status bits stripped and a calibration offset removed. A fractional gain correction is then applied to the offset-corrected value. The offset is a signed byte and the gain is a signed 16-bit word, and both arrive on plain input ports alongside each sample. The offset is always removed before the gain is applied.

The datapath is a three-stage pipeline that accepts one sample on every clock. The stages are subtract, multiply, and scale-and-add. Each result leaves with a valid strobe and a flag that marks the converter's overflow. The gain term is the full-width product of the offset-corrected value and the gain word, shifted right arithmetically by 16. The shift therefore rounds toward negative infinity. The sum clamps to the 16-bit range instead of wrapping. Only the upper 13 bits of a result are meaningful: a sign, two bits that rounding makes unreliable, and 10 data bits. The block still delivers all 16 bits.

Top module: `adc_corrector`

## Requirements
- R1: Let D = S − 16·F, where S is the signed value of raw bits 15..3 followed by three zero bits, and F is the signed offset byte. The output is sat16(D + floor(D·G / 65536)), where G is the signed gain word.
- R2: Raw bits 2 and 1 have no effect on the output sample.
- R3: Raw bit 0 is the overflow flag. It appears on `out_bad` together with the result of its own sample, and it does not change the sample value.
- R4: The offset byte is sign-extended and weighted by 16 (bit 0 of the byte lines up with raw bit 4). A negative offset therefore raises the result.
- R5: The product D·G is formed at full width before scaling, so a small gain on a large D still yields a nonzero term. The scaling rounds toward negative infinity.
- R6: A sum above 32767 gives 32767, and a sum below −32768 gives −32768.
- R7: `out_vld` is exactly `in_vld` delayed by three clocks, and each result appears three clocks after its input is accepted.
- R8: A synchronous active-high `rst` clears every pipeline valid bit. Samples in flight are lost, and `out_vld` is 0 from the first clock of reset onward.
- R9: With a gain word of 0, the output equals sat16(D).
- R10: Samples accepted on consecutive clocks each produce their own correct result, in order, with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| raw_word | input | 16 | Raw converter word: sign in bit 15, data in 14..3, pad in 2..1, overflow in bit 0 |
| ofs_cal | input | 8 | Signed offset calibration byte |
| gain_cal | input | 16 | Signed gain calibration word, scaled by 2^16 |
| out_vld | output | 1 | Result strobe |
| out_sample | output | 16 | Corrected, saturated two's-complement sample |
| out_bad | output | 1 | Overflow flag of the sample now on the output |

## Verification
The bench aims at the sign and alignment of the offset. A negative byte must add to the result; a design that zero-extends it or misplaces the shift produces errors of 16 or 4096 times the byte. It drives tiny gains on large values and small negative products. A design that scales before multiplying yields a term of 0, and one that rounds toward zero is off by one on negative terms. Extreme codes with extreme calibration push the sum past both 16-bit limits, where a non-saturating design wraps to the opposite sign. Reset is raised while a sample is in flight, and the pad and overflow bits are toggled, so that stray outputs or data that depends on those bits are reported.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
    // Default geometry of the corrector; the top module re-exports these as parameters.
    localparam int RAW_W_DEF     = 16;
    localparam int OFS_W_DEF     = 8;
    localparam int GAIN_W_DEF    = 16;
    localparam int OFS_SHIFT_DEF = 4;
    localparam int FLAG_BITS_DEF = 3;
    localparam int SCALE_SH_DEF  = 16;

    // Extra sum growth needed when the gain can exceed unity magnitude.
    function automatic int gain_growth(input int gain_w, input int scale_sh);
        return (gain_w - 1 > scale_sh) ? (gain_w - 1 - scale_sh) : 0;
    endfunction
endpackage

// File: rtl/adc_corr_sub.sv
// Stage 1: strip the status bits, align the offset, subtract.
module adc_corr_sub #(
    parameter int RAW_W     = 16,
    parameter int OFS_W     = 8,
    parameter int GAIN_W    = 16,
    parameter int OFS_SHIFT = 4,
    parameter int FLAG_BITS = 3,
    localparam int DIFF_W   = RAW_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic              vld_o,
    output logic              bad_o,
    output logic [DIFF_W-1:0] diff_o,
    output logic [GAIN_W-1:0] gain_o
);
    logic [DIFF_W-1:0] data_x;
    logic [DIFF_W-1:0] ofs_x;
    logic              unused_pad;

    // Data field, sign-extended by one bit, low status bits forced to zero.
    assign data_x = {{(DIFF_W-RAW_W){raw_i[RAW_W-1]}},
                     raw_i[RAW_W-1:FLAG_BITS], {FLAG_BITS{1'b0}}};
    // Offset byte sign-extended and moved up to the data's weight.
    assign ofs_x  = {{(DIFF_W-OFS_W-OFS_SHIFT){ofs_i[OFS_W-1]}},
                     ofs_i, {OFS_SHIFT{1'b0}}};
    assign unused_pad = ^raw_i[FLAG_BITS-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        bad_o  <= raw_i[0];
        diff_o <= data_x - ofs_x;
        gain_o <= gain_i;
    end
endmodule

// File: rtl/adc_corr_mul.sv
// Stage 2: full-width signed product of the corrected value and the gain.
module adc_corr_mul #(
    parameter int DIFF_W   = 17,
    parameter int GAIN_W   = 16,
    localparam int PROD_W  = DIFF_W + GAIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic              bad_i,
    input  logic [DIFF_W-1:0] diff_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic              vld_o,
    output logic              bad_o,
    output logic [DIFF_W-1:0] diff_o,
    output logic [PROD_W-1:0] prod_o
);
    logic [PROD_W-1:0] diff_x;
    logic [PROD_W-1:0] gain_x;
    logic [PROD_W-1:0] prod_d;

    assign diff_x = {{GAIN_W{diff_i[DIFF_W-1]}}, diff_i};
    assign gain_x = {{DIFF_W{gain_i[GAIN_W-1]}}, gain_i};
    assign prod_d = $signed(diff_x) * $signed(gain_x);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        bad_o  <= bad_i;
        diff_o <= diff_i;
        prod_o <= prod_d;
    end
endmodule

// File: rtl/adc_corr_scale.sv
// Stage 3: floor-scale the product, add it to the corrected value, clamp.
module adc_corr_scale #(
    parameter int DIFF_W   = 17,
    parameter int PROD_W   = 33,
    parameter int SCALE_SH = 16,
    parameter int GROW     = 0,
    parameter int OUT_W    = 16,
    localparam int TERM_W  = PROD_W - SCALE_SH,
    localparam int SUM_W   = DIFF_W + 1 + GROW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic              bad_i,
    input  logic [DIFF_W-1:0] diff_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic              vld_o,
    output logic              bad_o,
    output logic [OUT_W-1:0]  res_o
);
    logic [TERM_W-1:0]      term;
    logic [SUM_W-1:0]       sum;
    logic [SUM_W-OUT_W:0]   top_bits;
    logic                   fits;
    logic [OUT_W-1:0]       clamped;
    logic                   unused_frac;

    // Dropping the low bits of a two's-complement value is a floor division.
    assign term        = prod_i[PROD_W-1:SCALE_SH];
    assign unused_frac = ^prod_i[SCALE_SH-1:0];
    assign sum = {{(SUM_W-DIFF_W){diff_i[DIFF_W-1]}}, diff_i}
               + {{(SUM_W-TERM_W){term[TERM_W-1]}}, term};
    assign top_bits = sum[SUM_W-1:OUT_W-1];
    assign fits     = (&top_bits) | ~(|top_bits);

    always_comb begin
        if (fits) begin
            clamped = sum[OUT_W-1:0];
        end else if (sum[SUM_W-1]) begin
            clamped = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            clamped = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        bad_o <= bad_i;
        res_o <= clamped;
    end
endmodule

// File: rtl/adc_corrector.sv
module adc_corrector
    import adc_corr_pkg::*;
#(
    parameter int RAW_W     = RAW_W_DEF,
    parameter int OFS_W     = OFS_W_DEF,
    parameter int GAIN_W    = GAIN_W_DEF,
    parameter int OFS_SHIFT = OFS_SHIFT_DEF,
    parameter int FLAG_BITS = FLAG_BITS_DEF,
    parameter int SCALE_SH  = SCALE_SH_DEF,
    localparam int DIFF_W   = RAW_W + 1,
    localparam int PROD_W   = DIFF_W + GAIN_W,
    localparam int GROW     = gain_growth(GAIN_W, SCALE_SH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [RAW_W-1:0]  raw_word,
    input  logic [OFS_W-1:0]  ofs_cal,
    input  logic [GAIN_W-1:0] gain_cal,
    output logic              out_vld,
    output logic [RAW_W-1:0]  out_sample,
    output logic              out_bad
);
    logic              s1_vld, s1_bad;
    logic [DIFF_W-1:0] s1_diff;
    logic [GAIN_W-1:0] s1_gain;
    logic              s2_vld, s2_bad;
    logic [DIFF_W-1:0] s2_diff;
    logic [PROD_W-1:0] s2_prod;

    adc_corr_sub #(
        .RAW_W(RAW_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W),
        .OFS_SHIFT(OFS_SHIFT), .FLAG_BITS(FLAG_BITS)
    ) u_sub (
        .clk(clk), .rst(rst), .vld_i(in_vld), .raw_i(raw_word),
        .ofs_i(ofs_cal), .gain_i(gain_cal),
        .vld_o(s1_vld), .bad_o(s1_bad), .diff_o(s1_diff), .gain_o(s1_gain)
    );

    adc_corr_mul #(
        .DIFF_W(DIFF_W), .GAIN_W(GAIN_W)
    ) u_mul (
        .clk(clk), .rst(rst), .vld_i(s1_vld), .bad_i(s1_bad),
        .diff_i(s1_diff), .gain_i(s1_gain),
        .vld_o(s2_vld), .bad_o(s2_bad), .diff_o(s2_diff), .prod_o(s2_prod)
    );

    adc_corr_scale #(
        .DIFF_W(DIFF_W), .PROD_W(PROD_W), .SCALE_SH(SCALE_SH),
        .GROW(GROW), .OUT_W(RAW_W)
    ) u_scale (
        .clk(clk), .rst(rst), .vld_i(s2_vld), .bad_i(s2_bad),
        .diff_i(s2_diff), .prod_i(s2_prod),
        .vld_o(out_vld), .bad_o(out_bad), .res_o(out_sample)
    );
endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
    parameter int RAW_W     = 16,
    parameter int OFS_W     = 8,
    parameter int GAIN_W    = 16,
    parameter int OFS_SHIFT = 4,
    parameter int FLAG_BITS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [RAW_W-1:0]  raw_word,
    input logic [OFS_W-1:0]  ofs_cal,
    input logic [GAIN_W-1:0] gain_cal,
    input logic              out_vld,
    input logic [RAW_W-1:0]  out_sample,
    input logic              out_bad
);
    localparam int DAT_W = RAW_W - FLAG_BITS;

    logic [1:0]        hist;
    logic [DAT_W-1:0]  dat_d  [3];
    logic [OFS_W-1:0]  ofs_d  [3];
    logic [GAIN_W-1:0] gain_d [3];
    int                ref_v;
    logic [RAW_W-1:0]  ref_sat;
    logic              unused_pad;

    assign unused_pad = ^raw_word[FLAG_BITS-1:1];

    // Clocks since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= 2'd0;
        end else if (hist != 2'd3) begin
            hist <= hist + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        dat_d[0]  <= raw_word[RAW_W-1:FLAG_BITS];
        ofs_d[0]  <= ofs_cal;
        gain_d[0] <= gain_cal;
        for (int k = 1; k < 3; k++) begin
            dat_d[k]  <= dat_d[k-1];
            ofs_d[k]  <= ofs_d[k-1];
            gain_d[k] <= gain_d[k-1];
        end
    end

    always_comb begin
        ref_v = int'($signed({dat_d[2], {FLAG_BITS{1'b0}}}))
              - int'($signed(ofs_d[2])) * (1 << OFS_SHIFT);
        if (ref_v > (1 << (RAW_W-1)) - 1) begin
            ref_sat = {1'b0, {(RAW_W-1){1'b1}}};
        end else if (ref_v < -(1 << (RAW_W-1))) begin
            ref_sat = {1'b1, {(RAW_W-1){1'b0}}};
        end else begin
            ref_sat = ref_v[RAW_W-1:0];
        end
    end

    // R7
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        (hist == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    // R8
    rst_chk: assert property (@(posedge clk) rst |=> !out_vld);

    // R3
    bad_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && hist == 2'd3) |-> (out_bad == $past(raw_word[0], 3)));

    // R9
    unity_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && hist == 2'd3 && gain_d[2] == '0) |-> (out_sample == ref_sat));
endmodule

bind adc_corrector adc_corr_chk #(
    .RAW_W(RAW_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W),
    .OFS_SHIFT(OFS_SHIFT), .FLAG_BITS(FLAG_BITS)
) i_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .raw_word(raw_word),
    .ofs_cal(ofs_cal), .gain_cal(gain_cal), .out_vld(out_vld),
    .out_sample(out_sample), .out_bad(out_bad)
);

// File: tb/test_adc_corrector.sv
module test_adc_corrector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] raw_word = '0;
    logic [7:0]  ofs_cal = '0;
    logic [15:0] gain_cal = '0;
    logic        out_vld;
    logic [15:0] out_sample;
    logic        out_bad;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h2468ACE1;

    typedef struct {
        logic [15:0] exp_val;
        logic        exp_bad;
        int          due;
        string       req;
    } item_t;
    item_t sb[$];

    adc_corrector i_adc_corrector (
        .clk(clk), .rst(rst), .in_vld(in_vld), .raw_word(raw_word),
        .ofs_cal(ofs_cal), .gain_cal(gain_cal), .out_vld(out_vld),
        .out_sample(out_sample), .out_bad(out_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [15:0] model(input logic [15:0] r, input logic [7:0] o,
                                          input logic [15:0] g);
        longint s, f, d, t, y;
        s = longint'($signed({r[15:3], 3'b000}));
        f = longint'($signed(o)) * 16;
        d = s - f;
        t = (d * longint'($signed(g))) >>> 16;
        y = d + t;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        return y[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic send(input logic [15:0] r, input logic [7:0] o, input logic [15:0] g,
                        input string req);
        item_t it;
        @(negedge clk);
        raw_word = r; ofs_cal = o; gain_cal = g; in_vld = 1'b1;
        it.exp_val = model(r, o, g);
        it.exp_bad = r[0];
        it.due     = cyc + 3;
        it.req     = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // Monitor: compare each produced result against the oldest expected item.
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 stray valid", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(out_sample == it.exp_val, it.req,
                    longint'($signed(out_sample)), longint'($signed(it.exp_val)));
                chk(out_bad == it.exp_bad, "R3 flag", out_bad, it.exp_bad);
                chk(cyc == it.due, "R7 latency", cyc, it.due);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R8 reset state", out_vld, 0);
        rst = 1'b0;
        idle(2);

        send(16'h1238, 8'h05, 16'h0100, "R1 basic");
        send(16'hC3A8, 8'h1F, 16'hF000, "R1 negative gain");
        send(16'h0FA0, 8'h80, 16'h8000, "R1 half gain");
        send(16'h2000, 8'hF0, 16'h0000, "R4 negative offset");
        send(16'h2000, 8'h10, 16'h0000, "R4 positive offset");
        send(16'h7D00, 8'h00, 16'h0003, "R5 small gain");
        send(16'hFFF8, 8'h00, 16'h0001, "R5 floor negative");
        send(16'h7FF8, 8'h80, 16'h7FFF, "R6 saturate high");
        send(16'h8000, 8'h7F, 16'h7FFF, "R6 saturate low");
        send(16'h7FF8, 8'h80, 16'h0000, "R9 unity clamp");
        send(16'h1230, 8'h22, 16'h1234, "R2 pad clear");
        send(16'h1236, 8'h22, 16'h1234, "R2 pad set");
        send(16'h1231, 8'h22, 16'h1234, "R3 overflow set");
        idle(1);
        send(16'h4567, 8'hC3, 16'hFEDC, "R3 overflow isolated");
        idle(6);
        chk(sb.size() == 0, "R7 drained", sb.size(), 0);

        // R10: back-to-back stream of pseudo-random samples.
        for (int i = 0; i < 40; i++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            send(seed[15:0], seed[23:16], {seed[31:24], seed[7:0]}, "R10 stream");
        end
        idle(6);
        chk(sb.size() == 0, "R10 all delivered", sb.size(), 0);

        // R8: reset while a sample is in flight drops it.
        send(16'h3338, 8'h01, 16'h0200, "R8 flushed");
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        sb.delete();
        @(negedge clk);
        chk(out_vld == 1'b0, "R8 in-flight cleared", out_vld, 0);
        rst = 1'b0;
        idle(5);
        chk(sb.size() == 0, "R8 no stray output", sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule